// File: doc/BRIEF.md
# General-Purpose I/O and Control Register Bank

This block is a bank of 16-bit registers sitting on a simple memory-mapped bus with a single-cycle write strobe and a single-cycle read strobe. It holds a mode word, a clock divider word, a clock control word, three interrupt words (request, mask, status), a power word and a fixed read-only status word. It also holds a small I/O unit of 16 lines built from a direction register and a level register.

The 16 output lines carry the level bits gated by the direction bits. They are refreshed only when software writes the direction register or the level register, and only when that product has changed. Between such writes, edges on the 16 input lines update the level register, so software reads them, but the output lines do not move. The block only stores the interrupt, clock and power words. Other logic gives them meaning.

Top module: `gpio_ctl_regs`

## Requirements
- R1: Only address bits [5:0] are decoded. The offsets are: mode 0x00, clock divider 0x04, status 0x08, power 0x0C, clock control 0x10, interrupt request 0x14, interrupt mask 0x18, interrupt status 0x1C, direction 0x20, level-write 0x24, level-read 0x28. While `rd_en` is high, `rd_data` returns the addressed register, zero-extended to 32 bits, in the same cycle. While `rd_en` is low, `rd_data` is 0.
- R2: A write stores only the low 16 bits of `wr_data`. This applies to the mode, clock divider, clock control and the three interrupt registers.
- R3: A write to the power offset stores the low 16 bits of the data. When bit 7 of the written value is 1, bits 15 and 6 are also set, so the mask 0x8040 is ORed in.
- R4: A write to 0x24 or to 0x28 stores (data AND direction) into the level register. A read of either offset returns the level register. A read of 0x20 returns the direction register.
- R5: One cycle after a direction or level write, `gpio_out` equals (level AND direction). Both values are taken as they stand after that write.
- R6: Apart from the update in R5, `gpio_out` holds its value. A change on `gpio_in` does not move `gpio_out` by itself.
- R7: The status register reads 0x0002. Writes to it are ignored.
- R8: When bit i of `gpio_in` rises, bit i of the level register is set one cycle later. When it falls, that bit is cleared one cycle later. This holds whatever the direction bit is.
- R9: When a level write and an input-line change happen in the same cycle, the bus value is stored for every bit and the input change is discarded.
- R10: A read of any other offset returns 0, including a misaligned one. A write to such an offset changes no register and no output.
- R11: After reset, every register reads 0 except status, and `gpio_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Read strobe; read data is combinational |
| addr | input | 12 | Byte address; only bits [5:0] decoded |
| wr_data | input | 32 | Write data; upper 16 bits ignored |
| rd_data | output | 32 | Read data, zero-extended |
| gpio_in | input | 16 | Input lines that set and clear level bits on edges |
| gpio_out | output | 16 | Output lines, level AND direction |

## Verification
The bench writes power values with bit 7 both set and clear. A design that forced 0x8040 unconditionally, or dropped the force, would read back wrong values. It also writes the level register with bits outside the direction mask, which catches a design that stores raw data.

It toggles input lines between direction writes and expects `gpio_out` to stay frozen. A design that drove the outputs straight from live state would move them early. It collides a level write with an input edge, where a design that lets the edge win leaves a stray 1. It writes and reads aliased, misaligned and unmapped addresses, which exposes decoders that ignore the upper offset bits or leak state.

// File: rtl/gpio_ctl_regs.sv
module gpio_ctl_regs #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int REG_W  = 16,
  parameter int NLINES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NLINES-1:0] gpio_in,
  output logic [NLINES-1:0] gpio_out
);

  localparam logic [5:0] OFF_MODE = 6'h00;
  localparam logic [5:0] OFF_CDIV = 6'h04;
  localparam logic [5:0] OFF_STAT = 6'h08;
  localparam logic [5:0] OFF_PWR  = 6'h0C;
  localparam logic [5:0] OFF_CCTL = 6'h10;
  localparam logic [5:0] OFF_IREQ = 6'h14;
  localparam logic [5:0] OFF_IMSK = 6'h18;
  localparam logic [5:0] OFF_ISTA = 6'h1C;
  localparam logic [5:0] OFF_DIR  = 6'h20;
  localparam logic [5:0] OFF_LVLW = 6'h24;
  localparam logic [5:0] OFF_LVLR = 6'h28;

  localparam logic [REG_W-1:0] STAT_VAL  = REG_W'(16'h0002);
  localparam logic [REG_W-1:0] PWR_FORCE = REG_W'(16'h8040);

  logic [5:0]       off;
  logic [REG_W-1:0] wd;
  logic [REG_W-1:0] mode_q, cdiv_q, pwr_q, cctl_q, ireq_q, imsk_q, ista_q;
  logic [NLINES-1:0] dir_q, lvl_q, in_q;
  logic [NLINES-1:0] dir_n, lvl_n, in_chg;
  logic             wr_dir, wr_lvl;
  logic [REG_W-1:0] rsel;
  logic             unused_bits;

  assign off         = addr[5:0];
  assign wd          = wr_data[REG_W-1:0];
  assign unused_bits = ^{addr[ADDR_W-1:6], wr_data[DATA_W-1:REG_W]};

  assign wr_dir = wr_en && (off == OFF_DIR);
  assign wr_lvl = wr_en && (off == OFF_LVLW || off == OFF_LVLR);
  assign in_chg = gpio_in ^ in_q;

  always_comb begin
    lvl_n = (lvl_q & ~in_chg) | (gpio_in & in_chg);
    if (wr_lvl) lvl_n = wd[NLINES-1:0] & dir_q;
    dir_n = wr_dir ? wd[NLINES-1:0] : dir_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0; cdiv_q <= '0; pwr_q  <= '0; cctl_q <= '0;
      ireq_q <= '0; imsk_q <= '0; ista_q <= '0;
    end else if (wr_en) begin
      case (off)
        OFF_MODE: mode_q <= wd;
        OFF_CDIV: cdiv_q <= wd;
        OFF_PWR:  pwr_q  <= wd | (wd[7] ? PWR_FORCE : '0);
        OFF_CCTL: cctl_q <= wd;
        OFF_IREQ: ireq_q <= wd;
        OFF_IMSK: imsk_q <= wd;
        OFF_ISTA: ista_q <= wd;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q    <= '0;
      lvl_q    <= '0;
      in_q     <= '0;
      gpio_out <= '0;
    end else begin
      dir_q <= dir_n;
      lvl_q <= lvl_n;
      in_q  <= gpio_in;
      if (wr_dir || wr_lvl) gpio_out <= lvl_n & dir_n;
    end
  end

  always_comb begin
    case (off)
      OFF_MODE: rsel = mode_q;
      OFF_CDIV: rsel = cdiv_q;
      OFF_STAT: rsel = STAT_VAL;
      OFF_PWR:  rsel = pwr_q;
      OFF_CCTL: rsel = cctl_q;
      OFF_IREQ: rsel = ireq_q;
      OFF_IMSK: rsel = imsk_q;
      OFF_ISTA: rsel = ista_q;
      OFF_DIR:  rsel = REG_W'(dir_q);
      OFF_LVLW, OFF_LVLR: rsel = REG_W'(lvl_q);
      default:  rsel = '0;
    endcase
  end

  assign rd_data = rd_en ? DATA_W'(rsel) : '0;

endmodule

// File: rtl/gpio_ctl_regs_chk.sv
module gpio_ctl_regs_chk #(
  parameter int DATA_W = 32,
  parameter int REG_W  = 16,
  parameter int NLINES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [5:0]        off,
  input logic [REG_W-1:0]  wd,
  input logic [DATA_W-1:0] rd_data,
  input logic [NLINES-1:0] gpio_out,
  input logic [NLINES-1:0] lvl,
  input logic [NLINES-1:0] dir,
  input logic [REG_W-1:0]  pwr
);
  logic io_wr, lvl_wr, mapped;
  assign lvl_wr = wr_en && (off == 6'h24 || off == 6'h28);
  assign io_wr  = lvl_wr || (wr_en && off == 6'h20);
  assign mapped = (off[1:0] == 2'b00) && (off <= 6'h28);

  a_r3_power_force: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && off == 6'h0C && wd[7]) |=> (pwr[15] && pwr[6]));

  a_r4_level_masked: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_wr |=> ((lvl & ~dir) == '0));

  a_r5_out_product: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr |=> (gpio_out == (lvl & dir)));

  a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr |=> $stable(gpio_out));

  a_r7_status_value: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && off == 6'h08) |-> (rd_data == DATA_W'(2)));

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !mapped) |-> (rd_data == '0));

  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == '0));
endmodule

bind gpio_ctl_regs gpio_ctl_regs_chk #(.DATA_W(DATA_W), .REG_W(REG_W), .NLINES(NLINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .off(addr[5:0]),
  .wd(wr_data[REG_W-1:0]), .rd_data(rd_data), .gpio_out(gpio_out),
  .lvl(lvl_q), .dir(dir_q), .pwr(pwr_q)
);

// File: tb/tb_gpio_ctl_regs.sv
module tb_gpio_ctl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [15:0] gpio_in = '0;
  logic [15:0] gpio_out;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  gpio_ctl_regs dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .gpio_in(gpio_in), .gpio_out(gpio_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    rd_en = 1'b1; addr = a;
    #1;
    check(req, rd_data, exp);
    rd_en = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    rd_chk("R11 mode", 12'h000, 0);
    rd_chk("R11 cdiv", 12'h004, 0);
    rd_chk("R7 status reset", 12'h008, 32'h2);
    rd_chk("R11 power", 12'h00C, 0);
    rd_chk("R11 ista", 12'h01C, 0);
    rd_chk("R11 dir", 12'h020, 0);
    rd_chk("R11 level", 12'h024, 0);
    check("R11 gpio_out", 32'(gpio_out), 0);
  endtask

  task automatic t_plain_regs;
    wr(12'h000, 32'hABCD_1234);
    rd_chk("R2 mode truncated", 12'h000, 32'h1234);
    wr(12'h140, 32'h0000_5A5A);
    rd_chk("R1 alias upper addr bits", 12'h000, 32'h5A5A);
    wr(12'h004, 32'hFFFF_0011);
    wr(12'h010, 32'h0000_0022);
    wr(12'h014, 32'h0000_0033);
    wr(12'h018, 32'h0000_0044);
    wr(12'h01C, 32'h0000_0055);
    rd_chk("R2 cdiv", 12'h004, 32'h0011);
    rd_chk("R2 cctl", 12'h010, 32'h0022);
    rd_chk("R2 ireq", 12'h014, 32'h0033);
    rd_chk("R2 imsk", 12'h018, 32'h0044);
    rd_chk("R2 ista", 12'h01C, 32'h0055);
    addr = 12'h000; #1;
    check("R1 idle read zero", rd_data, 0);
  endtask

  task automatic t_power;
    wr(12'h00C, 32'h0000_0081);
    rd_chk("R3 bit7 forces", 12'h00C, 32'h80C1);
    wr(12'h00C, 32'h0000_0001);
    rd_chk("R3 no force", 12'h00C, 32'h0001);
    wr(12'h00C, 32'h0000_0F80);
    rd_chk("R3 force merge", 12'h00C, 32'h8FC0);
    wr(12'h00C, 32'h0000_7F7F);
    rd_chk("R3 bit7 clear", 12'h00C, 32'h7F7F);
  endtask

  task automatic t_status;
    wr(12'h008, 32'h0000_FFFF);
    rd_chk("R7 status write ignored", 12'h008, 32'h2);
  endtask

  task automatic t_level;
    wr(12'h020, 32'h0000_00FF);
    rd_chk("R4 dir read", 12'h020, 32'h00FF);
    check("R5 out after dir, level 0", 32'(gpio_out), 0);
    wr(12'h024, 32'h0000_1234);
    rd_chk("R4 level masked", 12'h028, 32'h0034);
    check("R5 out after level write", 32'(gpio_out), 32'h0034);
    wr(12'h028, 32'h0000_FFFF);
    rd_chk("R4 write via read offset", 12'h024, 32'h00FF);
    check("R5 out 0x00FF", 32'(gpio_out), 32'h00FF);
  endtask

  task automatic t_inputs;
    @(negedge clk); gpio_in[12] = 1'b1;
    @(negedge clk);
    rd_chk("R8 input rise sets level", 12'h024, 32'h10FF);
    check("R6 out frozen on input", 32'(gpio_out), 32'h00FF);
    wr(12'h020, 32'h0000_F0FF);
    check("R5 out after dir", 32'(gpio_out), 32'h10FF);
    @(negedge clk); gpio_in[12] = 1'b0;
    @(negedge clk);
    rd_chk("R8 input fall clears level", 12'h024, 32'h00FF);
    check("R6 out holds after fall", 32'(gpio_out), 32'h10FF);
    wr(12'h020, 32'h0000_F0FF);
    check("R5 refresh same dir", 32'(gpio_out), 32'h00FF);
  endtask

  task automatic t_collide;
    @(negedge clk);
    wr_en = 1'b1; addr = 12'h024; wr_data = 32'h0;
    gpio_in[9] = 1'b1; gpio_in[3] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    rd_chk("R9 bus write wins", 12'h024, 32'h0000);
    check("R9 out zero", 32'(gpio_out), 0);
    gpio_in = '0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_unmapped;
    wr(12'h024, 32'h0000_00AA);
    wr(12'h02C, 32'h0000_FFFF);
    wr(12'h001, 32'h0000_FFFF);
    wr(12'h03C, 32'h0000_FFFF);
    rd_chk("R10 read 0x2C", 12'h02C, 0);
    rd_chk("R10 read 0x3C", 12'h03C, 0);
    rd_chk("R10 read misaligned", 12'h001, 0);
    rd_chk("R10 mode untouched", 12'h000, 32'h5A5A);
    rd_chk("R10 dir untouched", 12'h020, 32'hF0FF);
    check("R10 out untouched", 32'(gpio_out), 32'h00AA);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_plain_regs;
    t_power;
    t_status;
    t_level;
    t_inputs;
    t_collide;
    t_unmapped;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule